// File: doc/BRIEF.md
# Soft-Start and Hiccup Fault Sequencer

This block is the digital timing core for a synchronous step-down converter's start-up and fault handling. It stands in for the soft-start capacitor with a saturating up/down counter. It also holds the over-current fault latch and reruns the start-up ramp after each fault. The counter value goes out as a ramp that a reference generator can follow. Three flags decode fixed points on that ramp:

- the point where the reference starts to follow it;
- the point where switching of the power stage is allowed;
- the point where the fast-transient window loop switches on.

A filtered over-current condition sets the fault latch at once, and the latch dominates any clear. If the fault arrives while the ramp is still rising, the ramp finishes its rise with the drivers held off. It then discharges at a slow, divided rate. The latch may clear only when the ramp has fallen to a low threshold and no over-current remains; a new soft start follows. A low enable or an undervoltage supply forces everything off and parks the ramp at zero. The supply is seen as a digitised code with a separate rise and fall threshold.

All pins are plain level signals sampled on the clock. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `ss_hiccup_seq`

## Requirements
- R1: While `en_i` is low, `drv_en_o`, `sec_loop_en_o` and `ref_track_o` are 0 in that same cycle, and `ss_cnt_o` is 0 from the next clock edge on.
- R2: The supply is judged good once `vcc_code_i >= VCC_ON` (143) and bad once `vcc_code_i <= VCC_OFF` (137); codes between keep the previous judgement. A bad supply has the same effect as a low enable, one edge later.
- R3: While the block is active, not faulted and sees no filtered over-current, `ss_cnt_o` rises by exactly 1 per clock.
- R4: `ref_track_o` is 1 exactly when the block is active and `ss_cnt_o >= TRACK_TH` (12).
- R5: `drv_en_o` is 1 exactly when the block is active, the fault latch is clear, no filtered over-current is present and `ss_cnt_o >= SW_TH` (28).
- R6: `sec_loop_en_o` is 1 exactly when `drv_en_o` is 1 and `ss_cnt_o >= SEC_TH` (80).
- R7: `ss_cnt_o` never exceeds `CLAMP` (96), and a clean start settles there.
- R8: A filtered over-current sets `fault_o` on the next edge even mid-ramp. A ramp that was rising keeps rising to `CLAMP` with the drivers off, then discharges.
- R9: During a fault the ramp falls by 1 once every `DIS_DIV` (10) clocks, floored at 0.
- R10: `fault_o` clears only when `ss_cnt_o <= CLEAR_TH` (10) and no filtered over-current is present. The ramp then climbs again from that value. If over-current persists, the ramp falls to 0 and stays there until the over-current goes away.
- R11: `oc_raw_i` counts as an over-current only after `OC_FILT` (5) consecutive high samples; any low sample restarts the count.
- R12: In reset, `ss_cnt_o` and every flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable level; low forces sleep |
| vcc_code_i | input | VCC_W (8) | Digitised supply voltage code |
| oc_raw_i | input | 1 | Unfiltered over-current comparator bit |
| ss_cnt_o | output | CNT_W (8) | Soft-start ramp count |
| fault_o | output | 1 | Fault latch state |
| drv_en_o | output | 1 | Power-stage switching allowed |
| sec_loop_en_o | output | 1 | Fast-transient window loop enabled |
| ref_track_o | output | 1 | Reference follows the ramp |

## Verification
The results have different latencies:

- **Enable low:** drops the three flags in the same cycle and zeroes the ramp at the next edge.
- **Supply code crossing:** reaches the flags one edge later through the registered hysteresis flag, and zeroes the ramp one edge after that.
- **Over-current:** `drv_en_o` drops right after the fifth consecutive high sample, and `fault_o` rises one edge later.
- **Discharge:** once in discharge, each one-count step of the ramp takes exactly ten clocks.

The table vectors hold each stimulus for a span far longer than these latencies and then sample between edges. The directed tests poll the ramp value cycle by cycle and compare the value at which each flag first rises, the spacing between discharge steps, and the count seen on the first cycle after the latch clears.

// File: rtl/ss_seq_pkg.sv
package ss_seq_pkg;
  typedef enum logic [1:0] {
    SS_IDLE   = 2'd0,
    SS_CHARGE = 2'd1,
    SS_RUN    = 2'd2,
    SS_DISCH  = 2'd3
  } ss_state_e;
endpackage

// File: rtl/ss_uvlo_hyst.sv
module ss_uvlo_hyst #(
  parameter int VW  = 8,
  parameter int ON  = 143,
  parameter int OFF = 137
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [VW-1:0] code_i,
  output logic          ok_o
);
  localparam logic [VW-1:0] ON_V  = VW'(ON);
  localparam logic [VW-1:0] OFF_V = VW'(OFF);

  logic ok_q;

  // Two thresholds: rise at ON, fall at OFF, hold in between.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ok_q <= 1'b0;
    else if (ok_q) ok_q <= (code_i > OFF_V);
    else ok_q <= (code_i >= ON_V);
  end

  assign ok_o = ok_q;
endmodule

// File: rtl/ss_oc_filter.sv
module ss_oc_filter #(
  parameter int N = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic flt_o
);
  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] FULL = CW'(N);

  logic [CW-1:0] run_q;

  // Consecutive-sample counter; any low sample restarts it.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else if (!raw_i) run_q <= '0;
    else if (run_q != FULL) run_q <= run_q + 1'b1;
  end

  assign flt_o = (run_q == FULL);
endmodule

// File: rtl/ss_ramp_ctrl.sv
module ss_ramp_ctrl
  import ss_seq_pkg::*;
#(
  parameter int CW       = 8,
  parameter int CLAMP    = 96,
  parameter int CLEAR_TH = 10,
  parameter int DIS_DIV  = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic          oc_flt_i,
  output logic [CW-1:0] cnt_o,
  output logic          fault_o
);
  localparam int PW = (DIS_DIV > 1) ? $clog2(DIS_DIV) : 1;
  localparam logic [CW-1:0] CLAMP_V  = CW'(CLAMP);
  localparam logic [CW-1:0] CLR_V    = CW'(CLEAR_TH);
  localparam logic [PW-1:0] PRE_LAST = PW'(DIS_DIV - 1);

  ss_state_e     st_q;
  logic [CW-1:0] cnt_q;
  logic          flt_q;
  logic [PW-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SS_IDLE;
      cnt_q <= '0;
      flt_q <= 1'b0;
      pre_q <= '0;
    end else if (!active_i) begin
      // Sleep or undervoltage: ramp parked at zero, latch still set-dominant.
      st_q  <= SS_IDLE;
      cnt_q <= '0;
      flt_q <= oc_flt_i;
      pre_q <= '0;
    end else begin
      unique case (st_q)
        SS_IDLE: begin
          if (oc_flt_i) flt_q <= 1'b1;
          else begin
            flt_q <= 1'b0;
            st_q  <= SS_CHARGE;
          end
        end
        SS_CHARGE: begin
          if (oc_flt_i) flt_q <= 1'b1;
          if (cnt_q >= CLAMP_V - 1'b1) begin
            // End of the charge cycle: a pending fault turns it into discharge.
            cnt_q <= CLAMP_V;
            pre_q <= '0;
            st_q  <= (flt_q || oc_flt_i) ? SS_DISCH : SS_RUN;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SS_RUN: begin
          if (oc_flt_i) begin
            flt_q <= 1'b1;
            pre_q <= '0;
            st_q  <= SS_DISCH;
          end
        end
        SS_DISCH: begin
          if (!oc_flt_i && (cnt_q <= CLR_V)) begin
            // Latch clears at the low threshold; restart from the current count.
            flt_q <= 1'b0;
            pre_q <= '0;
            st_q  <= SS_CHARGE;
          end else if (pre_q == PRE_LAST) begin
            pre_q <= '0;
            if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
          end else begin
            pre_q <= pre_q + 1'b1;
          end
        end
        default: st_q <= SS_IDLE;
      endcase
    end
  end

  assign cnt_o   = cnt_q;
  assign fault_o = flt_q;
endmodule

// File: rtl/ss_flag_dec.sv
module ss_flag_dec #(
  parameter int CW       = 8,
  parameter int TRACK_TH = 12,
  parameter int SW_TH    = 28,
  parameter int SEC_TH   = 80
) (
  input  logic          active_i,
  input  logic          fault_i,
  input  logic          oc_flt_i,
  input  logic [CW-1:0] cnt_i,
  output logic          ref_track_o,
  output logic          drv_en_o,
  output logic          sec_loop_en_o
);
  localparam int NTH = 3;
  localparam logic [CW-1:0] TH_V [NTH] = '{CW'(TRACK_TH), CW'(SW_TH), CW'(SEC_TH)};

  logic [NTH-1:0] above;

  for (genvar g = 0; g < NTH; g++) begin : g_cmp
    assign above[g] = (cnt_i >= TH_V[g]);
  end

  logic drv_ok;
  assign drv_ok        = active_i && !fault_i && !oc_flt_i && above[1];
  assign ref_track_o   = active_i && above[0];
  assign drv_en_o      = drv_ok;
  assign sec_loop_en_o = drv_ok && above[2];
endmodule

// File: rtl/ss_hiccup_seq.sv
module ss_hiccup_seq #(
  parameter int CNT_W    = 8,
  parameter int TRACK_TH = 12,
  parameter int SW_TH    = 28,
  parameter int SEC_TH   = 80,
  parameter int CLAMP    = 96,
  parameter int CLEAR_TH = 10,
  parameter int DIS_DIV  = 10,
  parameter int OC_FILT  = 5,
  parameter int VCC_W    = 8,
  parameter int VCC_ON   = 143,
  parameter int VCC_OFF  = 137
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [VCC_W-1:0] vcc_code_i,
  input  logic             oc_raw_i,
  output logic [CNT_W-1:0] ss_cnt_o,
  output logic             fault_o,
  output logic             drv_en_o,
  output logic             sec_loop_en_o,
  output logic             ref_track_o
);
  logic uv_ok;
  logic oc_flt;
  logic active;
  logic [CNT_W-1:0] cnt;
  logic fault;

  ss_uvlo_hyst #(.VW(VCC_W), .ON(VCC_ON), .OFF(VCC_OFF)) u_uvlo (
    .clk_i(clk_i), .rst_ni(rst_ni), .code_i(vcc_code_i), .ok_o(uv_ok)
  );

  ss_oc_filter #(.N(OC_FILT)) u_ocf (
    .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(oc_raw_i), .flt_o(oc_flt)
  );

  assign active = en_i && uv_ok;

  ss_ramp_ctrl #(.CW(CNT_W), .CLAMP(CLAMP), .CLEAR_TH(CLEAR_TH), .DIS_DIV(DIS_DIV)) u_ramp (
    .clk_i(clk_i), .rst_ni(rst_ni), .active_i(active), .oc_flt_i(oc_flt),
    .cnt_o(cnt), .fault_o(fault)
  );

  ss_flag_dec #(.CW(CNT_W), .TRACK_TH(TRACK_TH), .SW_TH(SW_TH), .SEC_TH(SEC_TH)) u_dec (
    .active_i(active), .fault_i(fault), .oc_flt_i(oc_flt), .cnt_i(cnt),
    .ref_track_o(ref_track_o), .drv_en_o(drv_en_o), .sec_loop_en_o(sec_loop_en_o)
  );

  assign ss_cnt_o = cnt;
  assign fault_o  = fault;
endmodule

// File: rtl/ss_hiccup_seq_chk.sv
module ss_hiccup_seq_chk #(
  parameter int CNT_W    = 8,
  parameter int SEC_TH   = 80,
  parameter int CLAMP    = 96,
  parameter int CLEAR_TH = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             oc_flt,
  input logic [CNT_W-1:0] ss_cnt_o,
  input logic             fault_o,
  input logic             drv_en_o,
  input logic             sec_loop_en_o
);
  localparam logic [CNT_W-1:0] CLAMP_V = CNT_W'(CLAMP);
  localparam logic [CNT_W-1:0] CLR_V   = CNT_W'(CLEAR_TH);
  localparam logic [CNT_W-1:0] SEC_V   = CNT_W'(SEC_TH);

  a_r1_sleep_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (ss_cnt_o == '0));

  a_r3_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ss_cnt_o > $past(ss_cnt_o)) |-> (ss_cnt_o == $past(ss_cnt_o) + 1'b1));

  a_r5_fault_blocks_drv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !drv_en_o);

  a_r6_sec_needs_drv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_loop_en_o |-> (drv_en_o && (ss_cnt_o >= SEC_V)));

  a_r7_clamp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_cnt_o <= CLAMP_V);

  a_r8_set_dominant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oc_flt |=> fault_o);

  a_r9_fall_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ss_cnt_o < $past(ss_cnt_o)) |-> ((ss_cnt_o == $past(ss_cnt_o) - 1'b1) || (ss_cnt_o == '0)));

  a_r10_clear_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fault_o) |-> (ss_cnt_o <= CLR_V));
endmodule

bind ss_hiccup_seq ss_hiccup_seq_chk #(
  .CNT_W(CNT_W), .SEC_TH(SEC_TH), .CLAMP(CLAMP), .CLEAR_TH(CLEAR_TH)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .oc_flt(oc_flt),
  .ss_cnt_o(ss_cnt_o), .fault_o(fault_o), .drv_en_o(drv_en_o),
  .sec_loop_en_o(sec_loop_en_o)
);

// File: tb/tb_ss_hiccup_seq.sv
`timescale 1ns/1ps
module tb_ss_hiccup_seq;
  localparam int TRACK_TH = 12;
  localparam int SW_TH    = 28;
  localparam int SEC_TH   = 80;
  localparam int CLAMP    = 96;
  localparam int CLEAR_TH = 10;
  localparam int DIS_DIV  = 10;
  localparam int OC_FILT  = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] vcc = 8'd0;
  logic       oc = 1'b0;
  logic [7:0] cnt;
  logic       flt, drv, sec, rtr;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  ss_hiccup_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .vcc_code_i(vcc), .oc_raw_i(oc),
    .ss_cnt_o(cnt), .fault_o(flt), .drv_en_o(drv), .sec_loop_en_o(sec),
    .ref_track_o(rtr)
  );

  typedef struct packed {
    logic        en;
    logic [7:0]  vcc;
    logic        oc;
    logic [15:0] cyc;
    logic [7:0]  cnt;
    logic        flt;
    logic        drv;
    logic        sec;
    logic        rtr;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'd200, 1'b0, 16'd200,  8'd96, 1'b0, 1'b1, 1'b1, 1'b1},
    '{1'b0, 8'd200, 1'b0, 16'd3,    8'd0,  1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 8'd200, 1'b0, 16'd200,  8'd96, 1'b0, 1'b1, 1'b1, 1'b1},
    '{1'b1, 8'd138, 1'b0, 16'd5,    8'd96, 1'b0, 1'b1, 1'b1, 1'b1},
    '{1'b1, 8'd137, 1'b0, 16'd3,    8'd0,  1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 8'd142, 1'b0, 16'd50,   8'd0,  1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 8'd143, 1'b0, 16'd200,  8'd96, 1'b0, 1'b1, 1'b1, 1'b1},
    '{1'b1, 8'd200, 1'b1, 16'd10,   8'd96, 1'b1, 1'b0, 1'b0, 1'b1},
    '{1'b1, 8'd200, 1'b1, 16'd3000, 8'd0,  1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b1, 8'd200, 1'b0, 16'd200,  8'd96, 1'b0, 1'b1, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_cnt(input int target, input int limit);
    for (int i = 0; i < limit; i++) begin
      if (int'(cnt) == target) break;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    // R12: reset state
    step(3);
    chk("R12", "cnt in reset", int'(cnt), 0);
    chk("R12", "flags in reset", {flt, drv, sec, rtr}, 0);
    rst_n = 1'b1;

    // Vector table (R1 R2 R3 R7 R8 R10)
    for (int v = 0; v < NV; v++) begin
      en  = VEC[v].en;
      vcc = VEC[v].vcc;
      oc  = VEC[v].oc;
      step(int'(VEC[v].cyc));
      chk("R1/R2/R7/R10 vec", $sformatf("cnt v%0d", v), int'(cnt), int'(VEC[v].cnt));
      chk("R8 vec", $sformatf("fault v%0d", v), int'(flt), int'(VEC[v].flt));
      chk("R5 vec", $sformatf("drv v%0d", v), int'(drv), int'(VEC[v].drv));
      chk("R6 vec", $sformatf("sec v%0d", v), int'(sec), int'(VEC[v].sec));
      chk("R4 vec", $sformatf("ref v%0d", v), int'(rtr), int'(VEC[v].rtr));
    end

    // R1: drivers drop in the same cycle as enable falls
    en = 1'b0;
    #1;
    chk("R1", "drv same cycle", int'(drv), 0);
    chk("R1", "ref same cycle", int'(rtr), 0);
    step(2);

    // R3 R4 R5 R6: threshold crossings during a clean ramp
    begin
      int f_ref, f_drv, f_sec, prev, bad_step;
      f_ref = -1; f_drv = -1; f_sec = -1; prev = 0; bad_step = 0;
      en = 1'b1;
      for (int i = 0; i < 300; i++) begin
        step(1);
        if (int'(cnt) != prev && int'(cnt) != prev + 1) bad_step++;
        prev = int'(cnt);
        if (rtr && f_ref < 0) f_ref = int'(cnt);
        if (drv && f_drv < 0) f_drv = int'(cnt);
        if (sec && f_sec < 0) f_sec = int'(cnt);
      end
      chk("R3", "non-unit charge steps", bad_step, 0);
      chk("R4", "ref first count", f_ref, TRACK_TH);
      chk("R5", "drv first count", f_drv, SW_TH);
      chk("R6", "sec first count", f_sec, SEC_TH);
      chk("R7", "settled count", int'(cnt), CLAMP);
    end

    // R11: one sample short of the filter length is ignored
    oc = 1'b1;
    step(OC_FILT - 1);
    oc = 1'b0;
    step(20);
    chk("R11", "short pulse fault", int'(flt), 0);
    chk("R11", "short pulse drv", int'(drv), 1);
    oc = 1'b1;
    step(OC_FILT);
    chk("R11", "full length drv off", int'(drv), 0);
    step(1);
    chk("R11", "full length fault", int'(flt), 1);
    oc = 1'b0;

    // R8 R9 R10: fault in the middle of a charge cycle
    en = 1'b0;
    step(2);
    en = 1'b1;
    wait_cnt(40, 200);
    oc = 1'b1;
    step(OC_FILT);
    oc = 1'b0;
    step(2);
    chk("R8", "fault mid charge", int'(flt), 1);
    chk("R8", "drv mid charge", int'(drv), 0);
    chk("R8", "still charging", int'(cnt > 8'd46), 1);
    begin
      int sec_seen, t, t1, t2, v0;
      sec_seen = 0;
      for (int i = 0; i < 200 && int'(cnt) != CLAMP; i++) begin
        if (sec) sec_seen++;
        step(1);
      end
      chk("R8", "ramp reaches clamp in fault", int'(cnt), CLAMP);
      chk("R8", "sec stays off", sec_seen, 0);
      t = 0; t1 = 0; t2 = 0;
      for (int i = 0; i < 100 && int'(cnt) == CLAMP; i++) begin step(1); t++; end
      t1 = t; v0 = int'(cnt);
      for (int i = 0; i < 100 && int'(cnt) == v0; i++) begin step(1); t++; end
      t2 = t;
      chk("R9", "discharge step spacing", t2 - t1, DIS_DIV);
      chk("R9", "discharge step size", v0 - int'(cnt), 1);
      for (int i = 0; i < 2000 && flt; i++) step(1);
      chk("R10", "count at clear", int'(cnt), CLEAR_TH);
      step(1);
      chk("R10", "recharge from clear point", int'(cnt), CLEAR_TH + 1);
    end

    // R12: reset in mid run
    wait_cnt(CLAMP, 200);
    rst_n = 1'b0;
    step(1);
    chk("R12", "cnt after mid reset", int'(cnt), 0);
    chk("R12", "flags after mid reset", {flt, drv, sec, rtr}, 0);

    summary();
    $finish;
  end
endmodule